// File: doc/BRIEF.md
# Serial Peripheral Slave Front End with Pause Control

This block is the serial front end of a small register-based peripheral. It watches a mode-0 serial bus (chip select active low, data captured on the rising clock edge and launched on the falling edge) by oversampling every bus pin with a faster system clock. A frame opens with an identity byte: a device-type nibble and two address bits that must agree with two strap pins. The second byte names an operation, a bank and a register. For a write, the third byte carries the data. For a read, the front end takes one byte back from the register core and shifts it out on the serial output.

A pause input lets the bus master freeze a frame part way through. While paused, clock edges are ignored and the bit position and partly shifted byte are kept. The transfer continues from the same bit once the pause is released. The serial output has a separate drive enable that is raised only while read data is being shifted out, so the input and output pins may share one wire. An active-low write-protect pin is synchronized and handed to the register core.

Top module: `spi_hold_slave`

## Requirements
- R1: Serial input bits are taken, most significant bit first, only on rising edges of the serial clock while chip select is low and the transfer is not paused.
- R2: Byte 0 is {device type[7:4], address[3:2], unused[1:0]}. If the type differs from DEV_TYPE (default 4'b0101) or the address differs from `strap_i`, the rest of the frame is ignored: no command pulse, no write pulse and no output drive.
- R3: Byte 1 is {operation[7:4], bank[3:2], register[1:0]}. When its last bit is taken, the three fields appear on `opcode_o`, `bank_o` and `reg_sel_o` and `cmd_valid_o` pulses for one cycle. The fields hold until the next command. Operation bit 7 set to 1 marks a read and set to 0 marks a write.
- R4: In a write frame, byte 2 appears on `wr_data_o` with a one-cycle `wr_valid_o` pulse, and only after all 24 bits have arrived.
- R5: In a read frame, `rd_data_i` is sampled in the cycle after `cmd_valid_o`. It is shifted out most significant bit first, and a new bit is launched on each falling edge, starting with the falling edge that follows the 16th rising edge.
- R6: `miso_oe_o` is high only from the first launched read bit until the 24th rising edge of a read frame. It stays low in write frames and ignored frames, and `miso_o` is 0 whenever `miso_oe_o` is low.
- R7: Raising chip select abandons the frame in progress. No write pulse follows from a partial frame, the drive enable drops, and the next frame starts from bit 0.
- R8: After reset, no frame is accepted until chip select has been seen going from high to low.
- R9: Pulling `hold_n_i` low while the serial clock is low pauses the transfer. Clock edges during the pause change neither the bit position nor the shifted data.
- R10: Raising `hold_n_i` while the serial clock is low resumes the transfer at the same bit position.
- R11: Changes of `hold_n_i` while the serial clock is high have no effect.
- R12: `wr_protect_o` is the inverse of `wp_n_i` after two-stage synchronization and one output register.
- R13: Bits after the 24th in a frame are ignored and cause no further command or write pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock from the bus master |
| csn_i | input | 1 | Chip select, active low |
| hold_n_i | input | 1 | Pause request, active low |
| mosi_i | input | 1 | Serial data from the master |
| wp_n_i | input | 1 | Write protect, active low |
| strap_i | input | ADDR_W | Device address strap pins |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Drive enable for the serial output pad |
| cmd_valid_o | output | 1 | One-cycle strobe for a decoded command |
| opcode_o | output | OP_W | Operation field of the command |
| bank_o | output | BANK_W | Bank select of the command |
| reg_sel_o | output | REG_W | Register select of the command |
| wr_valid_o | output | 1 | One-cycle strobe for a received write byte |
| wr_data_o | output | BYTE_W | Received write byte |
| rd_data_i | input | BYTE_W | Read byte returned by the register core |
| wr_protect_o | output | 1 | Synchronized write protect, active high |

## Verification
On every cycle, the assertions check that the command and write strobes last one cycle and never coincide, that the bit position stays frozen for every cycle the pause is in force, that the output enable falls right after deselection, and that a write strobe never comes while the output is driven. Only the bench scenarios can show the byte values that come out of complete frames, the order and timing of the shifted read bits, that a released pause continues at the right bit, that a pause glitch during a high clock phase is ignored, and that address mismatches, partial frames, over-long frames and the missing chip-select edge after reset are rejected.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_CMD,
    ST_DATA,
    ST_SKIP
  } frame_st_t;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= RST_VAL[i];
        sync_q <= RST_VAL[i];
      end else begin
        meta_q <= d_i[i];
        sync_q <= meta_q;
      end
    end
    assign q_o[i] = sync_q;
  end
endmodule

// File: rtl/spi_edge_gate.sv
module spi_edge_gate (
  input  logic clk,
  input  logic rst,
  input  logic sck_s,
  input  logic csn_s,
  input  logic hold_n_s,
  output logic rise_o,
  output logic fall_o,
  output logic cs_fall_o,
  output logic cs_high_o,
  output logic paused_o
);
  logic sck_d, csn_d, paused_q;

  // chip-select history resets to "selected" so a pin held low through
  // reset does not look like a fresh falling edge
  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d    <= 1'b0;
      csn_d    <= 1'b0;
      paused_q <= 1'b0;
    end else begin
      sck_d <= sck_s;
      csn_d <= csn_s;
      if (csn_s)       paused_q <= 1'b0;
      else if (!sck_s) paused_q <= !hold_n_s;
    end
  end

  assign rise_o    = sck_s & ~sck_d & ~paused_q & ~csn_s;
  assign fall_o    = ~sck_s & sck_d & ~paused_q & ~csn_s;
  assign cs_fall_o = ~csn_s & csn_d;
  assign cs_high_o = csn_s;
  assign paused_o  = paused_q;
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_hold_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int TYPE_W = 4,
  parameter int ADDR_W = 2,
  parameter int OP_W   = 4,
  parameter int BANK_W = 2,
  parameter int REG_W  = 2,
  parameter logic [TYPE_W-1:0] DEV_TYPE = 4'b0101,
  localparam int CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise_i,
  input  logic              cs_fall_i,
  input  logic              cs_high_i,
  input  logic              mosi_s,
  input  logic [ADDR_W-1:0] strap_i,
  output logic              cmd_valid_o,
  output logic [OP_W-1:0]   op_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [REG_W-1:0]  reg_o,
  output logic              wr_valid_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_phase_o,
  output logic [CNT_W-1:0]  bit_cnt_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  frame_st_t         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-2:0] sh_q;
  logic              is_rd_q;
  logic [BYTE_W-1:0] byte_nxt;
  logic              byte_ok;

  assign byte_nxt = {sh_q, mosi_s};
  assign byte_ok  = (byte_nxt[BYTE_W-1 -: TYPE_W] == DEV_TYPE) &&
                    (byte_nxt[BYTE_W-TYPE_W-1 -: ADDR_W] == strap_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      sh_q        <= '0;
      is_rd_q     <= 1'b0;
      cmd_valid_o <= 1'b0;
      wr_valid_o  <= 1'b0;
      op_o        <= '0;
      bank_o      <= '0;
      reg_o       <= '0;
      wr_data_o   <= '0;
    end else begin
      cmd_valid_o <= 1'b0;
      wr_valid_o  <= 1'b0;
      if (cs_high_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else if (cs_fall_i) begin
        state_q <= ST_DEV;
        cnt_q   <= '0;
        is_rd_q <= 1'b0;
      end else if (rise_i && (state_q == ST_DEV || state_q == ST_CMD ||
                              state_q == ST_DATA)) begin
        sh_q  <= byte_nxt[BYTE_W-2:0];
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST_BIT) begin
          case (state_q)
            ST_DEV:  state_q <= byte_ok ? ST_CMD : ST_SKIP;
            ST_CMD: begin
              state_q     <= ST_DATA;
              cmd_valid_o <= 1'b1;
              op_o        <= byte_nxt[BYTE_W-1 -: OP_W];
              bank_o      <= byte_nxt[REG_W +: BANK_W];
              reg_o       <= byte_nxt[REG_W-1:0];
              is_rd_q     <= byte_nxt[BYTE_W-1];
            end
            default: begin
              state_q <= ST_SKIP;
              if (!is_rd_q) begin
                wr_valid_o <= 1'b1;
                wr_data_o  <= byte_nxt;
              end
            end
          endcase
        end
      end
    end
  end

  assign rd_phase_o = (state_q == ST_DATA) && is_rd_q;
  assign bit_cnt_o  = cnt_q;
endmodule

// File: rtl/spi_tx.sv
module spi_tx #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid_i,
  input  logic              rd_phase_i,
  input  logic              fall_i,
  input  logic              cs_high_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              miso_o,
  output logic              miso_oe_o
);
  logic              cap_q;
  logic [BYTE_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q     <= 1'b0;
      sh_q      <= '0;
      miso_o    <= 1'b0;
      miso_oe_o <= 1'b0;
    end else begin
      cap_q <= cmd_valid_i & rd_phase_i;
      if (cs_high_i || !rd_phase_i) begin
        miso_o    <= 1'b0;
        miso_oe_o <= 1'b0;
      end else if (cap_q) begin
        sh_q <= rd_data_i;
      end else if (fall_i) begin
        miso_o    <= sh_q[BYTE_W-1];
        miso_oe_o <= 1'b1;
        sh_q      <= {sh_q[BYTE_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_hold_slave.sv
module spi_hold_slave
  import spi_hold_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int TYPE_W = 4,
  parameter int ADDR_W = 2,
  parameter int OP_W   = 4,
  parameter int BANK_W = 2,
  parameter int REG_W  = 2,
  parameter logic [TYPE_W-1:0] DEV_TYPE = 4'b0101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_i,
  input  logic              csn_i,
  input  logic              hold_n_i,
  input  logic              mosi_i,
  input  logic              wp_n_i,
  input  logic [ADDR_W-1:0] strap_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic              cmd_valid_o,
  output logic [OP_W-1:0]   opcode_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [REG_W-1:0]  reg_sel_o,
  output logic              wr_valid_o,
  output logic [BYTE_W-1:0] wr_data_o,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              wr_protect_o
);
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam int N_SYNC = 5;
  // order {wp_n, mosi, hold_n, csn, sck}
  localparam logic [N_SYNC-1:0] SYNC_RST = 5'b10100;

  logic [N_SYNC-1:0] pins_s;
  logic sck_s, csn_s, hold_n_s, mosi_s, wp_n_s;
  logic rise, fall, cs_fall, cs_high, paused, rd_phase;
  logic [CNT_W-1:0] bit_cnt;

  spi_in_sync #(.W(N_SYNC), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst),
    .d_i({wp_n_i, mosi_i, hold_n_i, csn_i, sck_i}),
    .q_o(pins_s)
  );
  assign {wp_n_s, mosi_s, hold_n_s, csn_s, sck_s} = pins_s;

  spi_edge_gate u_edge (
    .clk(clk), .rst(rst),
    .sck_s(sck_s), .csn_s(csn_s), .hold_n_s(hold_n_s),
    .rise_o(rise), .fall_o(fall), .cs_fall_o(cs_fall),
    .cs_high_o(cs_high), .paused_o(paused)
  );

  spi_frame #(
    .BYTE_W(BYTE_W), .TYPE_W(TYPE_W), .ADDR_W(ADDR_W), .OP_W(OP_W),
    .BANK_W(BANK_W), .REG_W(REG_W), .DEV_TYPE(DEV_TYPE)
  ) u_frame (
    .clk(clk), .rst(rst),
    .rise_i(rise), .cs_fall_i(cs_fall), .cs_high_i(cs_high),
    .mosi_s(mosi_s), .strap_i(strap_i),
    .cmd_valid_o(cmd_valid_o), .op_o(opcode_o), .bank_o(bank_o),
    .reg_o(reg_sel_o), .wr_valid_o(wr_valid_o), .wr_data_o(wr_data_o),
    .rd_phase_o(rd_phase), .bit_cnt_o(bit_cnt)
  );

  spi_tx #(.BYTE_W(BYTE_W)) u_tx (
    .clk(clk), .rst(rst),
    .cmd_valid_i(cmd_valid_o), .rd_phase_i(rd_phase),
    .fall_i(fall), .cs_high_i(cs_high), .rd_data_i(rd_data_i),
    .miso_o(miso_o), .miso_oe_o(miso_oe_o)
  );

  always_ff @(posedge clk) begin
    if (rst) wr_protect_o <= 1'b0;
    else     wr_protect_o <= ~wp_n_s;
  end
endmodule

// File: rtl/spi_hold_chk.sv
module spi_hold_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_high,
  input logic             paused,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             cmd_valid,
  input logic             wr_valid,
  input logic             miso_oe
);
  p_cmd_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  p_cmd_wr_apart_r3: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && wr_valid));

  p_wr_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid);

  p_hold_freeze_r9: assert property (@(posedge clk) disable iff (rst)
    (paused && !cs_high) |=> $stable(bit_cnt));

  p_oe_off_deselect_r7: assert property (@(posedge clk) disable iff (rst)
    cs_high |=> !miso_oe);

  p_write_no_drive_r6: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> !miso_oe);
endmodule

bind spi_hold_slave spi_hold_chk #(.CNT_W($clog2(BYTE_W))) u_chk (
  .clk(clk), .rst(rst), .cs_high(cs_high), .paused(paused),
  .bit_cnt(bit_cnt), .cmd_valid(cmd_valid_o), .wr_valid(wr_valid_o),
  .miso_oe(miso_oe_o)
);

// File: tb/tb_spi_hold_slave.sv
module tb_spi_hold_slave;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, csn = 1'b1, hold_n = 1'b1, mosi = 1'b0, wp_n = 1'b1;
  logic [1:0] strap = 2'b10;
  logic miso, miso_oe, cmd_valid, wr_valid, wr_protect;
  logic [3:0] opcode;
  logic [1:0] bank, reg_sel;
  logic [7:0] wr_data, rd_data;

  int n_chk = 0, n_fail = 0;
  int n_cmd = 0, n_wr = 0, n_oe = 0;
  logic [7:0] last_cmd = '0, last_wr = '0;

  always #10 clk = ~clk;

  spi_hold_slave dut (
    .clk(clk), .rst(rst), .sck_i(sck), .csn_i(csn), .hold_n_i(hold_n),
    .mosi_i(mosi), .wp_n_i(wp_n), .strap_i(strap), .miso_o(miso),
    .miso_oe_o(miso_oe), .cmd_valid_o(cmd_valid), .opcode_o(opcode),
    .bank_o(bank), .reg_sel_o(reg_sel), .wr_valid_o(wr_valid),
    .wr_data_o(wr_data), .rd_data_i(rd_data), .wr_protect_o(wr_protect)
  );

  // register core stand-in: read value depends on the selected location
  function automatic logic [7:0] core_val(input logic [1:0] b, input logic [1:0] r);
    return 8'h96 ^ {b, r, b, r};
  endfunction
  assign rd_data = core_val(bank, reg_sel);

  always @(negedge clk) begin
    if (cmd_valid) begin n_cmd++; last_cmd = {opcode, bank, reg_sel}; end
    if (wr_valid)  begin n_wr++;  last_wr = wr_data; end
    if (miso_oe)   n_oe++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic cs_level);
    csn = cs_level; sck = 1'b0; hold_n = 1'b1;
    rst = 1'b1; clks(4); rst = 1'b0; clks(4);
  endtask

  task automatic sbit(input logic b, input bit glitch, output logic so);
    mosi = b; clks(H);
    so = miso; sck = 1'b1;
    if (glitch) begin clks(2); hold_n = 1'b0; clks(3); hold_n = 1'b1; clks(H - 5); end
    else clks(H);
    sck = 1'b0;
  endtask

  task automatic pause_hold();
    clks(4); hold_n = 1'b0; clks(6);
    for (int k = 0; k < 2; k++) begin
      mosi = ~mosi; sck = 1'b1; clks(6); sck = 1'b0; clks(6);
    end
    hold_n = 1'b1; clks(6);
  endtask

  task automatic run_frame(input logic [31:0] word, input int nbits, input int hold_a,
                           input int hold_b, input int glitch_at, input bit do_fall,
                           output logic [7:0] rx);
    logic so;
    rx = '0;
    if (do_fall) begin csn = 1'b1; clks(H); csn = 1'b0; end
    clks(H);
    for (int i = 0; i < nbits; i++) begin
      if (i == hold_a || i == hold_b) pause_hold();
      sbit(word[31-i], i == glitch_at, so);
      if (i >= 16 && i < 24) rx[23-i] = so;
    end
    clks(H); csn = 1'b1; clks(10);
  endtask

  task automatic t_reset();
    do_reset(1'b1);
    chk(miso_oe == 1'b0, "R6 oe after reset", miso_oe, 0);
    chk(miso == 1'b0, "R6 miso after reset", miso, 0);
    chk(n_cmd == 0 && n_wr == 0, "R8 no strobes after reset", n_cmd + n_wr, 0);
  endtask

  task automatic t_no_fall();
    logic [7:0] rx;
    int c0 = n_cmd, w0 = n_wr;
    do_reset(1'b0);
    run_frame({8'h58, 8'h39, 8'h11, 8'h00}, 24, -1, -1, -1, 1'b0, rx);
    chk(n_cmd == c0 && n_wr == w0, "R8 frame without select edge ignored", n_cmd - c0, 0);
  endtask

  task automatic t_write(input logic [7:0] d, input int ha, input int hb, input string tag);
    logic [7:0] rx;
    int c0 = n_cmd, w0 = n_wr, o0 = n_oe;
    run_frame({8'h58, 8'h39, d, 8'h00}, 24, ha, hb, -1, 1'b1, rx);
    chk(n_cmd == c0 + 1, {tag, " R3 one command"}, n_cmd - c0, 1);
    chk(last_cmd == 8'h39, {tag, " R3 fields op=3 bank=2 reg=1"}, last_cmd, 8'h39);
    chk(n_wr == w0 + 1 && last_wr == d, {tag, " R1 R4 write byte"}, last_wr, d);
    chk(n_oe == o0, {tag, " R6 no drive in write"}, n_oe - o0, 0);
  endtask

  task automatic t_read(input logic [7:0] cmd, input int ha, input string tag);
    logic [7:0] rx, exp;
    int w0 = n_wr, o0 = n_oe;
    exp = core_val(cmd[3:2], cmd[1:0]);
    run_frame({8'h58, cmd, 8'h00, 8'h00}, 24, ha, -1, -1, 1'b1, rx);
    chk(last_cmd == cmd, {tag, " R3 read command fields"}, last_cmd, cmd);
    chk(rx == exp, {tag, " R5 shifted read byte"}, rx, exp);
    chk(n_oe > o0 && n_wr == w0, {tag, " R6 drive during read only"}, n_oe - o0, 1);
    chk(miso_oe == 1'b0 && miso == 1'b0, {tag, " R6 released after frame"}, miso_oe, 0);
  endtask

  task automatic t_mismatch(input logic [7:0] b0, input string tag);
    logic [7:0] rx;
    int c0 = n_cmd, w0 = n_wr, o0 = n_oe;
    run_frame({b0, 8'h97, 8'h00, 8'h00}, 24, -1, -1, -1, 1'b1, rx);
    chk(n_cmd == c0 && n_wr == w0 && n_oe == o0, {tag, " R2 frame ignored"},
        n_cmd - c0 + n_wr - w0 + n_oe - o0, 0);
  endtask

  task automatic t_abort();
    logic [7:0] rx;
    int w0 = n_wr, o0 = n_oe;
    run_frame({8'h58, 8'h39, 8'hF0, 8'h00}, 20, -1, -1, -1, 1'b1, rx);
    chk(n_wr == w0, "R7 partial write dropped", n_wr - w0, 0);
    run_frame({8'h58, 8'h97, 8'h00, 8'h00}, 19, -1, -1, -1, 1'b1, rx);
    chk(n_oe > o0 && miso_oe == 1'b0, "R7 drive drops on deselect", miso_oe, 0);
  endtask

  task automatic t_glitch();
    logic [7:0] rx;
    int w0 = n_wr;
    run_frame({8'h58, 8'h39, 8'h6B, 8'h00}, 24, -1, -1, 19, 1'b1, rx);
    chk(n_wr == w0 + 1 && last_wr == 8'h6B, "R11 high-phase pause glitch ignored", last_wr, 8'h6B);
  endtask

  task automatic t_long();
    logic [7:0] rx;
    int c0 = n_cmd, w0 = n_wr;
    run_frame({8'h58, 8'h39, 8'h2D, 8'hFF}, 32, -1, -1, -1, 1'b1, rx);
    chk(n_cmd == c0 + 1 && n_wr == w0 + 1, "R13 one command and one write", n_wr - w0, 1);
    chk(last_wr == 8'h2D, "R13 extra byte ignored", last_wr, 8'h2D);
  endtask

  task automatic t_wp();
    wp_n = 1'b0; clks(5);
    chk(wr_protect == 1'b1, "R12 protect asserted", wr_protect, 1);
    wp_n = 1'b1; clks(5);
    chk(wr_protect == 1'b0, "R12 protect released", wr_protect, 0);
  endtask

  bit done = 1'b0;
  initial begin
    t_reset();
    t_no_fall();
    do_reset(1'b1);
    t_write(8'h3C, -1, -1, "plain");
    t_write(8'hC5, 3, 20, "paused R9 R10");
    t_read(8'h97, -1, "read");
    t_read(8'hA2, 19, "read paused R9");
    t_mismatch(8'h54, "addr");
    t_mismatch(8'h78, "type");
    t_abort();
    t_write(8'h81, 10, -1, "after abort R7");
    t_glitch();
    t_long();
    t_wp();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule